// File: doc/BRIEF.md
# Turbo Speed Control Register Block

This block sits on an 8-bit processor bus and owns the settings that tell a memory slot scheduler how fast the processor may run. It stores a speed index and a flag that turns off the stall that normally happens on bad raster lines. It sends the effective speed index and a badline-enable flag to the scheduler every cycle. A two-bit mode selector from a configuration menu decides where those outputs come from. In one mode they are fixed at base speed. In another they follow the menu. In the other two modes the bus registers set them.

Software sees a control register, an enable register, and a pair of write-only compatibility registers that pick normal or turbo speed. There is also a read-only detect register with its own enable input. Each register is visible only in the modes that allow it. A read of any hidden register, or of an address with no register, returns 0xFF. Writes to a hidden register are dropped.

Top module: `turbo_ctrl_regs`

## Requirements
- R1: In off mode (mode_sel = 0) eff_speed is 0 and eff_badline_en is 1, whatever the registers and menu inputs hold.
- R2: In manual mode (mode_sel = 1) eff_speed equals menu_speed and eff_badline_en equals the inverse of menu_badline_off. Register writes made in this mode have no effect.
- R3: After reset, rd_data is 0xFF and the enable bit is 1. The control register holds menu_speed in bits 3:0 and menu_badline_off in bit 7, with bits 6:4 cleared. These menu values are the ones sampled during reset.
- R4: The control register is at address 0xD031. In register mode (mode_sel = 2) and enable-bit mode (mode_sel = 3) all eight bits are written and read back. Bits 3:0 are the speed index. Bit 7 set to 1 disables badline timing. In register mode the outputs follow this register.
- R5: In off and manual modes, a read of 0xD031 returns 0xFF and a write to it leaves the stored value unchanged.
- R6: The enable register at 0xD030 is usable only in enable-bit mode. In any other mode it reads 0xFF and writes to it are ignored.
- R7: In enable-bit mode, writing 0 to bit 0 of 0xD030 forces eff_speed to 0 with badlines enabled. Writing 1 makes the outputs follow the control register.
- R8: In enable-bit mode, a read of 0xD030 returns bits 7:1 as ones. Bit 0 is 1 when eff_speed is nonzero (turbo on) and 0 otherwise.
- R9: In register and enable-bit modes, a write of any value to 0xD07A sets the stored speed index to 0. A write of any value to 0xD07B sets it to TURBO_IDX (default 11). Bit 7 is left as it was. Both addresses read 0xFF. In off and manual modes these writes are ignored.
- R10: The detect register at 0xD0BC reads DETECT_VALUE (default 0x80) when detect_en is 1 and 0xFF when it is 0. Writes to it change nothing.
- R11: rd_data is loaded on the clock edge that samples rd_en and holds its value otherwise. A read of an address with no visible register, including any address outside page 0xD0, returns 0xFF. A write to such an address changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | Mode from menu: 0 off, 1 manual, 2 register, 3 enable-bit |
| menu_speed | input | 4 | Speed index chosen in the menu |
| menu_badline_off | input | 1 | Menu choice: 1 disables badline timing |
| detect_en | input | 1 | Makes the detect register visible |
| addr | input | 16 | Bus address |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Registered read data |
| eff_speed | output | 4 | Effective speed index to the scheduler |
| eff_badline_en | output | 1 | 1 when the processor must stall on badlines |

## Verification
The assertions check on every cycle that the off and manual outputs are correct. They also check that the stored registers cannot change when the mode or address makes them inaccessible, that a turbo-select write loads the 20 MHz index, and that a read of an unmapped or hidden address returns all ones. Only the bench scenarios can show the actual values read back. These include the control register contents, the split meaning of the enable bit between write and read, the menu values loaded at reset, and that a value written in one mode is still there after the mode changes.

// File: rtl/turbo_pkg.sv
package turbo_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 16;

    typedef enum logic [1:0] {
        MODE_OFF    = 2'd0,
        MODE_MANUAL = 2'd1,
        MODE_REGS   = 2'd2,
        MODE_ENBIT  = 2'd3
    } mode_e;

    localparam logic [7:0] OFS_ENABLE = 8'h30;
    localparam logic [7:0] OFS_CTRL   = 8'h31;
    localparam logic [7:0] OFS_NORMAL = 8'h7A;
    localparam logic [7:0] OFS_TURBO  = 8'h7B;
    localparam logic [7:0] OFS_DETECT = 8'hBC;

    localparam int CTRL_BL_BIT = 7;

    typedef struct packed {
        logic ctrl;
        logic enable;
        logic normal;
        logic turbo;
        logic detect;
    } reg_sel_t;

    function automatic logic regs_writable(mode_e m);
        return (m == MODE_REGS) || (m == MODE_ENBIT);
    endfunction

endpackage

// File: rtl/turbo_addr_decode.sv
module turbo_addr_decode
    import turbo_pkg::*;
#(
    parameter logic [7:0] BASE_PAGE = 8'hD0
) (
    input  logic [ADDR_W-1:0] addr,
    input  mode_e             mode,
    input  logic              detect_en,
    output reg_sel_t          acc
);
    logic     page_hit;
    reg_sel_t hit;

    always_comb begin
        page_hit    = (addr[ADDR_W-1:8] == BASE_PAGE);
        hit.ctrl    = page_hit && (addr[7:0] == OFS_CTRL);
        hit.enable  = page_hit && (addr[7:0] == OFS_ENABLE);
        hit.normal  = page_hit && (addr[7:0] == OFS_NORMAL);
        hit.turbo   = page_hit && (addr[7:0] == OFS_TURBO);
        hit.detect  = page_hit && (addr[7:0] == OFS_DETECT);

        acc.ctrl    = hit.ctrl   && regs_writable(mode);
        acc.normal  = hit.normal && regs_writable(mode);
        acc.turbo   = hit.turbo  && regs_writable(mode);
        acc.enable  = hit.enable && (mode == MODE_ENBIT);
        acc.detect  = hit.detect && detect_en;
    end
endmodule

// File: rtl/turbo_reg_state.sv
module turbo_reg_state
    import turbo_pkg::*;
#(
    parameter int                SPEED_W   = 4,
    parameter logic [SPEED_W-1:0] TURBO_IDX = SPEED_W'(11)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [DATA_W-1:0]  wr_data,
    input  reg_sel_t           acc,
    input  logic [SPEED_W-1:0] menu_speed,
    input  logic               menu_badline_off,
    output logic [DATA_W-1:0]  ctrl_q,
    output logic               turbo_en_q
);
    localparam int PAD_W = DATA_W - 1 - SPEED_W;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q     <= {menu_badline_off, {PAD_W{1'b0}}, menu_speed};
            turbo_en_q <= 1'b1;
        end else if (wr_en) begin
            if (acc.ctrl)
                ctrl_q <= wr_data;
            else if (acc.normal)
                ctrl_q[SPEED_W-1:0] <= '0;
            else if (acc.turbo)
                ctrl_q[SPEED_W-1:0] <= TURBO_IDX;
            if (acc.enable)
                turbo_en_q <= wr_data[0];
        end
    end

    p_ctrl_locked_r5: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && (acc.ctrl || acc.normal || acc.turbo)) |=> $stable(ctrl_q));

    p_enable_locked_r6: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && acc.enable) |=> $stable(turbo_en_q));

    p_turbo_idx_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && acc.turbo) |=> (ctrl_q[SPEED_W-1:0] == TURBO_IDX));
endmodule

// File: rtl/turbo_eff_select.sv
module turbo_eff_select
    import turbo_pkg::*;
#(
    parameter int SPEED_W = 4
) (
    input  mode_e              mode,
    input  logic [SPEED_W-1:0] menu_speed,
    input  logic               menu_badline_off,
    input  logic [DATA_W-1:0]  ctrl_q,
    input  logic               turbo_en_q,
    output logic [SPEED_W-1:0] eff_speed,
    output logic               eff_badline_en
);
    always_comb begin
        eff_speed      = '0;
        eff_badline_en = 1'b1;
        unique case (mode)
            MODE_OFF: ;
            MODE_MANUAL: begin
                eff_speed      = menu_speed;
                eff_badline_en = !menu_badline_off;
            end
            MODE_REGS: begin
                eff_speed      = ctrl_q[SPEED_W-1:0];
                eff_badline_en = !ctrl_q[CTRL_BL_BIT];
            end
            MODE_ENBIT: begin
                if (turbo_en_q) begin
                    eff_speed      = ctrl_q[SPEED_W-1:0];
                    eff_badline_en = !ctrl_q[CTRL_BL_BIT];
                end
            end
        endcase
    end
endmodule

// File: rtl/turbo_ctrl_regs.sv
module turbo_ctrl_regs
    import turbo_pkg::*;
#(
    parameter int                 SPEED_W      = 4,
    parameter logic [SPEED_W-1:0] TURBO_IDX    = SPEED_W'(11),
    parameter logic [7:0]         BASE_PAGE    = 8'hD0,
    parameter logic [7:0]         DETECT_VALUE = 8'h80
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [1:0]         mode_sel,
    input  logic [SPEED_W-1:0] menu_speed,
    input  logic               menu_badline_off,
    input  logic               detect_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic               wr_en,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               rd_en,
    output logic [DATA_W-1:0]  rd_data,
    output logic [SPEED_W-1:0] eff_speed,
    output logic               eff_badline_en
);
    mode_e              mode;
    reg_sel_t           acc;
    logic [DATA_W-1:0]  ctrl_q;
    logic               turbo_en_q;
    logic [DATA_W-1:0]  rd_next;

    assign mode = mode_e'(mode_sel);

    turbo_addr_decode #(.BASE_PAGE(BASE_PAGE)) u_decode (
        .addr      (addr),
        .mode      (mode),
        .detect_en (detect_en),
        .acc       (acc)
    );

    turbo_reg_state #(.SPEED_W(SPEED_W), .TURBO_IDX(TURBO_IDX)) u_state (
        .clk              (clk),
        .rst              (rst),
        .wr_en            (wr_en),
        .wr_data          (wr_data),
        .acc              (acc),
        .menu_speed       (menu_speed),
        .menu_badline_off (menu_badline_off),
        .ctrl_q           (ctrl_q),
        .turbo_en_q       (turbo_en_q)
    );

    turbo_eff_select #(.SPEED_W(SPEED_W)) u_eff (
        .mode             (mode),
        .menu_speed       (menu_speed),
        .menu_badline_off (menu_badline_off),
        .ctrl_q           (ctrl_q),
        .turbo_en_q       (turbo_en_q),
        .eff_speed        (eff_speed),
        .eff_badline_en   (eff_badline_en)
    );

    always_comb begin
        rd_next = '1;
        if (acc.ctrl)
            rd_next = ctrl_q;
        else if (acc.enable)
            rd_next = {{(DATA_W-1){1'b1}}, (eff_speed != '0)};
        else if (acc.detect)
            rd_next = DETECT_VALUE;
    end

    always_ff @(posedge clk) begin
        if (rst)
            rd_data <= '1;
        else if (rd_en)
            rd_data <= rd_next;
    end

    p_off_outputs_r1: assert property (@(posedge clk) disable iff (rst)
        (mode_sel == 2'd0) |-> (eff_speed == '0 && eff_badline_en));

    p_manual_follow_r2: assert property (@(posedge clk) disable iff (rst)
        (mode_sel == 2'd1) |-> (eff_speed == menu_speed && eff_badline_en == !menu_badline_off));

    p_hidden_reads_ff_r11: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !(acc.ctrl || acc.enable || acc.detect)) |=> (rd_data == 8'hFF));
endmodule

// File: tb/test_turbo_ctrl_regs.sv
module test_turbo_ctrl_regs;
    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  mode_sel;
    logic [3:0]  menu_speed;
    logic        menu_badline_off;
    logic        detect_en;
    logic [15:0] addr;
    logic        wr_en;
    logic [7:0]  wr_data;
    logic        rd_en;
    logic [7:0]  rd_data;
    logic [3:0]  eff_speed;
    logic        eff_badline_en;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    turbo_ctrl_regs i_turbo_ctrl_regs (
        .clk(clk), .rst(rst), .mode_sel(mode_sel), .menu_speed(menu_speed),
        .menu_badline_off(menu_badline_off), .detect_en(detect_en), .addr(addr),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .eff_speed(eff_speed), .eff_badline_en(eff_badline_en)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic set_mode(input logic [1:0] m);
        @(negedge clk);
        mode_sel = m;
        #1;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        check("R3 rd_data after reset", rd_data, 8'hFF);
        check("R3 speed from menu", eff_speed, 5);
        check("R3 badline from menu", eff_badline_en, 1);
        bus_read(16'hD031, d);
        check("R3 ctrl reset value", d, 8'h05);
        set_mode(2'd3);
        check("R3 enable bit resets to 1", eff_speed, 5);
        set_mode(2'd2);
    endtask

    task automatic t_off();
        logic [7:0] d;
        set_mode(2'd0);
        check("R1 off speed", eff_speed, 0);
        check("R1 off badline", eff_badline_en, 1);
        bus_read(16'hD031, d);
        check("R5 ctrl hidden in off", d, 8'hFF);
        bus_write(16'hD031, 8'h8F);
        bus_write(16'hD07B, 8'h00);
        bus_read(16'hD030, d);
        check("R6 enable hidden in off", d, 8'hFF);
        bus_write(16'hD030, 8'h00);
        set_mode(2'd2);
        bus_read(16'hD031, d);
        check("R5 ctrl write ignored in off", d, 8'h05);
        set_mode(2'd3);
        check("R6 enable write ignored in off", eff_speed, 5);
        set_mode(2'd2);
    endtask

    task automatic t_manual();
        logic [7:0] d;
        set_mode(2'd1);
        menu_speed = 4'd9; menu_badline_off = 1'b1; #1;
        check("R2 manual speed", eff_speed, 9);
        check("R2 manual badline", eff_badline_en, 0);
        bus_write(16'hD031, 8'h0C);
        bus_write(16'hD07B, 8'h00);
        check("R2 manual ignores writes", eff_speed, 9);
        bus_read(16'hD031, d);
        check("R5 ctrl hidden in manual", d, 8'hFF);
        set_mode(2'd2);
        bus_read(16'hD031, d);
        check("R9 compat ignored in manual", d, 8'h05);
        menu_speed = 4'd5; menu_badline_off = 1'b0;
    endtask

    task automatic t_ctrl();
        logic [7:0] d;
        bus_write(16'hD031, 8'hF3);
        bus_read(16'hD031, d);
        check("R4 ctrl readback", d, 8'hF3);
        check("R4 regs speed", eff_speed, 3);
        check("R4 regs badline off", eff_badline_en, 0);
        bus_read(16'hD030, d);
        check("R6 enable hidden in regs", d, 8'hFF);
    endtask

    task automatic t_enbit();
        logic [7:0] d;
        set_mode(2'd3);
        check("R7 enbit follows ctrl", eff_speed, 3);
        bus_write(16'hD030, 8'h00);
        check("R7 forced speed", eff_speed, 0);
        check("R7 forced badline", eff_badline_en, 1);
        bus_read(16'hD030, d);
        check("R8 read turbo off", d, 8'hFE);
        bus_write(16'hD030, 8'h01);
        check("R7 restored speed", eff_speed, 3);
        check("R7 restored badline", eff_badline_en, 0);
        bus_read(16'hD030, d);
        check("R8 read turbo on", d, 8'hFF);
        bus_write(16'hD031, 8'h00);
        bus_read(16'hD030, d);
        check("R8 speed 0 reads off", d, 8'hFE);
        bus_read(16'hD031, d);
        check("R4 ctrl written in enbit", d, 8'h00);
    endtask

    task automatic t_compat();
        logic [7:0] d;
        set_mode(2'd2);
        bus_write(16'hD031, 8'h84);
        bus_write(16'hD07B, 8'h3C);
        check("R9 turbo select speed", eff_speed, 11);
        bus_read(16'hD031, d);
        check("R9 turbo keeps bit7", d, 8'h8B);
        bus_read(16'hD07B, d);
        check("R9 turbo select write-only", d, 8'hFF);
        bus_write(16'hD07A, 8'hA5);
        check("R9 normal select speed", eff_speed, 0);
        bus_read(16'hD07A, d);
        check("R9 normal select write-only", d, 8'hFF);
    endtask

    task automatic t_detect();
        logic [7:0] d;
        detect_en = 1'b0;
        bus_read(16'hD0BC, d);
        check("R10 detect hidden", d, 8'hFF);
        detect_en = 1'b1;
        bus_read(16'hD0BC, d);
        check("R10 detect visible", d, 8'h80);
        bus_write(16'hD0BC, 8'h12);
        bus_read(16'hD0BC, d);
        check("R10 detect read-only", d, 8'h80);
        set_mode(2'd0);
        bus_read(16'hD0BC, d);
        check("R10 detect in off mode", d, 8'h80);
        set_mode(2'd2);
    endtask

    task automatic t_page();
        logic [7:0] d;
        bus_write(16'hD031, 8'h07);
        bus_read(16'hD131, d);
        check("R11 other page reads ff", d, 8'hFF);
        bus_write(16'hD131, 8'h77);
        bus_read(16'hD031, d);
        check("R11 other page write ignored", d, 8'h07);
        bus_read(16'hD032, d);
        check("R11 unmapped offset", d, 8'hFF);
        @(negedge clk);
        addr = 16'hD031;
        @(negedge clk);
        check("R11 rd_data holds without rd_en", rd_data, 8'hFF);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; mode_sel = 2'd2; menu_speed = 4'd5; menu_badline_off = 1'b0;
        detect_en = 1'b0; addr = 16'h0000; wr_en = 1'b0; wr_data = 8'h00; rd_en = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        t_reset();
        t_off();
        t_manual();
        t_ctrl();
        t_enbit();
        t_compat();
        t_detect();
        t_page();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule